// File: doc/BRIEF.md
# Legacy Interrupt Conditioning Block

This block shapes three legacy interrupt sources before they reach the system interrupt controller. Each of the keyboard and mouse request lines either passes straight through or, under a per-line enable, is reduced to a sticky flag. The flag is set by a rising edge and held until software reads the keyboard/mouse data port. The block learns of that read by snooping I/O cycles. A low-active coprocessor error input can be routed, under a third enable, to an internal IRQ13 request. While that request stands, the block also drives a low-active ignore-numeric-error output. Both are released when software writes the error-clear I/O port.

Software controls the three enables through one 32-bit read/write control word. The word is reached over a plain offset/data/strobe register port. The enable bit positions are fixed, because software decodes them. The request lines and the error input are asynchronous to the block clock and are synchronised inside.

Top module: `lirq_cond`

## Requirements
- R1: The control word sits at register offset 8'hD0 and resets to 32'h0000_0000. Bits 13, 12 and 11 are written by `reg_we_i` at that offset. `reg_rdata_o` shows the word while `reg_re_i` is high at that offset, and is zero otherwise.
- R2: Every bit other than 13, 12 and 11 reads as zero and ignores writes.
- R3: With bit 12 clear, `irq1_o` equals `irq1_raw_i` with no clock delay. With bit 11 clear, `irq12_o` equals `irq12_raw_i` in the same way.
- R4: With bit 12 set, a rising edge on `irq1_raw_i` makes `irq1_o` high from the third rising clock edge after the input rises. The output stays high after the input falls, until a data-port read.
- R5: With bit 11 set, `irq12_raw_i` is captured and held on `irq12_o` in the same way as in R4.
- R6: A read of I/O port 16'h0060 (`io_rd_i` with `io_addr_i` = 16'h0060) clears both held flags at the next clock edge. An I/O write to that port clears nothing. A rising edge detected in the same cycle as the read keeps its flag set.
- R7: Clearing bit 12 or bit 11 returns that output to pass-through from the write's clock edge and discards the held flag. Setting the bit again does not bring the flag back.
- R8: With bit 13 clear, `irq13_o` is low and `ignne_no` is high whatever `ferr_ni` does. Clearing bit 13 drops an active request from the write's clock edge.
- R9: With bit 13 set, a low level on `ferr_ni` makes `irq13_o` high and `ignne_no` low from the third rising clock edge after `ferr_ni` falls. Both stay asserted after `ferr_ni` returns high, and an I/O read of 16'h00F0 does not release them.
- R10: An I/O write to port 16'h00F0 releases `irq13_o` and `ignne_no` at the next clock edge. If `ferr_ni` is still low, both assert again one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 8 | Register offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_rdata_o | output | 32 | Register read data, combinational |
| io_addr_i | input | 16 | Snooped I/O cycle address |
| io_rd_i | input | 1 | Snooped I/O read strobe |
| io_wr_i | input | 1 | Snooped I/O write strobe |
| irq1_raw_i | input | 1 | Keyboard request, active high |
| irq12_raw_i | input | 1 | Mouse request, active high |
| ferr_ni | input | 1 | Coprocessor error, active low |
| irq1_o | output | 1 | Conditioned keyboard request |
| irq12_o | output | 1 | Conditioned mouse request |
| irq13_o | output | 1 | Coprocessor error request |
| ignne_no | output | 1 | Ignore numeric error, active low |

## Verification
Pass-through outputs and register read data are combinational, so the bench checks them one time step after it changes the input. A request that is edge-captured or an error that is level-captured needs three clock edges: two for synchronisation, and one for the edge register or the request flag. The bench samples at the falling edge after the second rising edge to confirm the output is still low, and after the third to confirm it is high. Clears by port snoop and enable writes act at the strobe's own clock edge, so they are checked at the next falling edge. The error re-assertion is checked one falling edge later than the clear.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int CFG_W       = 32;
  localparam int CFG_OFFSET  = 'hD0;
  localparam int ERR_EN_BIT  = 13;
  localparam int KBD_LEN_BIT = 12;
  localparam int MSE_LEN_BIT = 11;
  localparam logic [CFG_W-1:0] CFG_RW_MASK =
    (CFG_W'(1) << ERR_EN_BIT) | (CFG_W'(1) << KBD_LEN_BIT) | (CFG_W'(1) << MSE_LEN_BIT);
  localparam int PORT_DATA    = 'h0060;
  localparam int PORT_ERR_CLR = 'h00F0;

  typedef struct packed {
    logic err_en;
    logic kbd_len;
    logic mse_len;
  } lirq_cfg_t;
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lirq_cfg_reg.sv
module lirq_cfg_reg
  import lirq_pkg::*;
#(
  parameter int REG_AW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [CFG_W-1:0]  rdata_o,
  output lirq_cfg_t         cfg_o
);
  logic             hit;
  logic [CFG_W-1:0] word_q;

  assign hit = (addr_i == REG_AW'(CFG_OFFSET));

  // reserved bits never stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         word_q <= '0;
    else if (we_i && hit) word_q <= wdata_i & CFG_RW_MASK;
  end

  assign rdata_o = (re_i && hit) ? word_q : '0;

  assign cfg_o.err_en  = word_q[ERR_EN_BIT];
  assign cfg_o.kbd_len = word_q[KBD_LEN_BIT];
  assign cfg_o.mse_len = word_q[MSE_LEN_BIT];
endmodule

// File: rtl/lirq_edge_latch.sv
module lirq_edge_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic raw_i,
  input  logic clr_i,
  output logic irq_o,
  output logic edge_o
);
  logic sync_d, prev_q, held_q;

  lirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (sync_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= sync_d;
  end

  assign edge_o = sync_d & ~prev_q;

  // new edge beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     held_q <= 1'b0;
    else if (!en_i)  held_q <= 1'b0;
    else if (edge_o) held_q <= 1'b1;
    else if (clr_i)  held_q <= 1'b0;
  end

  assign irq_o = en_i ? held_q : raw_i;
endmodule

// File: rtl/lirq_err_ctl.sv
module lirq_err_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic ferr_ni,
  input  logic clr_i,
  output logic irq13_o,
  output logic ignne_no,
  output logic err_act_o
);
  logic ferr_s, req_q;

  lirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ferr_ni),
    .q_o   (ferr_s)
  );

  assign err_act_o = ~ferr_s;

  // clear wins for one cycle; a standing error re-arms next cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        req_q <= 1'b0;
    else if (!en_i)     req_q <= 1'b0;
    else if (clr_i)     req_q <= 1'b0;
    else if (err_act_o) req_q <= 1'b1;
  end

  assign irq13_o  = en_i & req_q;
  assign ignne_no = ~irq13_o;
endmodule

// File: rtl/lirq_cond.sv
module lirq_cond
  import lirq_pkg::*;
#(
  parameter int REG_AW      = 8,
  parameter int IO_AW       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [CFG_W-1:0]  reg_wdata_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  output logic [CFG_W-1:0]  reg_rdata_o,
  input  logic [IO_AW-1:0]  io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic              irq1_raw_i,
  input  logic              irq12_raw_i,
  input  logic              ferr_ni,
  output logic              irq1_o,
  output logic              irq12_o,
  output logic              irq13_o,
  output logic              ignne_no
);
  localparam int NCH = 2;

  lirq_cfg_t      cfg_q;
  logic           data_rd, err_clr_wr, err_act;
  logic [NCH-1:0] ch_en, ch_raw, ch_irq, edge_det;

  lirq_cfg_reg #(.REG_AW(REG_AW)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .we_i   (reg_we_i),
    .re_i   (reg_re_i),
    .rdata_o(reg_rdata_o),
    .cfg_o  (cfg_q)
  );

  assign data_rd    = io_rd_i && (io_addr_i == IO_AW'(PORT_DATA));
  assign err_clr_wr = io_wr_i && (io_addr_i == IO_AW'(PORT_ERR_CLR));

  assign ch_en  = {cfg_q.mse_len, cfg_q.kbd_len};
  assign ch_raw = {irq12_raw_i, irq1_raw_i};

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    lirq_edge_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (ch_en[ch]),
      .raw_i (ch_raw[ch]),
      .clr_i (data_rd),
      .irq_o (ch_irq[ch]),
      .edge_o(edge_det[ch])
    );
  end

  assign irq1_o  = ch_irq[0];
  assign irq12_o = ch_irq[1];

  lirq_err_ctl #(.SYNC_STAGES(SYNC_STAGES)) u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (cfg_q.err_en),
    .ferr_ni  (ferr_ni),
    .clr_i    (err_clr_wr),
    .irq13_o  (irq13_o),
    .ignne_no (ignne_no),
    .err_act_o(err_act)
  );
endmodule

// File: rtl/lirq_cond_chk.sv
module lirq_cond_chk
  import lirq_pkg::*;
#(
  parameter int REG_AW = 8,
  parameter int IO_AW  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [REG_AW-1:0] reg_addr_i,
  input logic              reg_we_i,
  input logic [CFG_W-1:0]  reg_rdata_o,
  input logic [IO_AW-1:0]  io_addr_i,
  input logic              io_rd_i,
  input logic              io_wr_i,
  input logic              irq1_o,
  input logic              irq12_o,
  input logic              irq13_o,
  input logic              ignne_no,
  input lirq_cfg_t         cfg_q,
  input logic [1:0]        edge_det,
  input logic              err_act
);
  logic cfg_wr, rd60, wr_f0;
  assign cfg_wr = reg_we_i && (reg_addr_i == REG_AW'(CFG_OFFSET));
  assign rd60   = io_rd_i && (io_addr_i == IO_AW'(PORT_DATA));
  assign wr_f0  = io_wr_i && (io_addr_i == IO_AW'(PORT_ERR_CLR));

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rdata_o & ~CFG_RW_MASK) == '0);

  p_kbd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.kbd_len && irq1_o && !rd60 && !cfg_wr) |=> irq1_o);

  p_mse_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mse_len && irq12_o && !rd60 && !cfg_wr) |=> irq12_o);

  p_data_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.kbd_len && rd60 && !edge_det[0] && !cfg_wr) |=> !irq1_o);

  p_edge_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.mse_len && rd60 && edge_det[1] && !cfg_wr) |=> irq12_o);

  p_err_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_q.err_en |-> (!irq13_o && ignne_no));

  p_err_set_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.err_en && err_act && !wr_f0 && !cfg_wr) |=> (irq13_o && !ignne_no));

  p_err_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q.err_en && wr_f0 && !cfg_wr) |=> (!irq13_o && ignne_no));
endmodule

bind lirq_cond lirq_cond_chk #(.REG_AW(REG_AW), .IO_AW(IO_AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_addr_i (reg_addr_i),
  .reg_we_i   (reg_we_i),
  .reg_rdata_o(reg_rdata_o),
  .io_addr_i  (io_addr_i),
  .io_rd_i    (io_rd_i),
  .io_wr_i    (io_wr_i),
  .irq1_o     (irq1_o),
  .irq12_o    (irq12_o),
  .irq13_o    (irq13_o),
  .ignne_no   (ignne_no),
  .cfg_q      (cfg_q),
  .edge_det   (edge_det),
  .err_act    (err_act)
);

// File: tb/lirq_cond_bench.sv
`timescale 1ns/1ps
module lirq_cond_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic        reg_we_i = 1'b0, reg_re_i = 1'b0;
  logic [31:0] reg_rdata_o;
  logic [15:0] io_addr_i = '0;
  logic        io_rd_i = 1'b0, io_wr_i = 1'b0;
  logic        irq1_raw_i = 1'b0, irq12_raw_i = 1'b0, ferr_ni = 1'b1;
  logic        irq1_o, irq12_o, irq13_o, ignne_no;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  lirq_cond u_lirq_cond (.*);

  typedef struct packed {
    logic [31:0] cfg;
    logic i1, i12, fn, e1, e12, e13;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{32'h0000_0000, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{32'hFFFF_C7FF, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
    '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h03C0_0780, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] a, input logic re, output logic [31:0] d);
    reg_addr_i = a; reg_re_i = re;
    #1 d = reg_rdata_o;
    reg_re_i = 1'b0;
  endtask

  task automatic io_cyc(input logic [15:0] a, input logic wr);
    io_addr_i = a; io_rd_i = ~wr; io_wr_i = wr;
    @(negedge clk_i);
    io_rd_i = 1'b0; io_wr_i = 1'b0;
  endtask

  initial begin
    logic [31:0] rd;
    cyc(3);
    chk("R1 reset irq13", {31'b0, irq13_o}, 32'h0);
    chk("R1 reset ignne", {31'b0, ignne_no}, 32'h1);
    rst_ni = 1'b1;
    cyc(1);
    reg_rd(8'hD0, 1'b1, rd);
    chk("R1 reset value", rd, 32'h0);

    for (int i = 0; i < NV; i++) begin
      reg_wr(8'hD0, VECS[i].cfg);
      irq1_raw_i = VECS[i].i1; irq12_raw_i = VECS[i].i12; ferr_ni = VECS[i].fn;
      cyc(4);
      chk("R3 table irq1", {31'b0, irq1_o}, {31'b0, VECS[i].e1});
      chk("R3 table irq12", {31'b0, irq12_o}, {31'b0, VECS[i].e12});
      chk("R8 table irq13", {31'b0, irq13_o}, {31'b0, VECS[i].e13});
      chk("R8 table ignne", {31'b0, ignne_no}, {31'b0, ~VECS[i].e13});
      reg_rd(8'hD0, 1'b1, rd);
      chk("R2 table readback", rd, VECS[i].cfg & 32'h0000_3800);
    end

    // R4/R5 capture and hold
    reg_wr(8'hD0, 32'h0000_1800);
    cyc(4);
    irq1_raw_i = 1'b1;
    cyc(2);
    chk("R4 not before third edge", {31'b0, irq1_o}, 32'h0);
    cyc(1);
    chk("R4 captured", {31'b0, irq1_o}, 32'h1);
    irq1_raw_i = 1'b0;
    cyc(3);
    chk("R4 held after input low", {31'b0, irq1_o}, 32'h1);
    irq12_raw_i = 1'b1;
    cyc(3);
    chk("R5 captured", {31'b0, irq12_o}, 32'h1);
    io_cyc(16'h0060, 1'b1);
    chk("R6 write to 60h ignored irq1", {31'b0, irq1_o}, 32'h1);
    chk("R6 write to 60h ignored irq12", {31'b0, irq12_o}, 32'h1);

    // R6 same-cycle edge beats clear
    cyc(1);
    irq1_raw_i = 1'b1;
    cyc(2);
    io_cyc(16'h0060, 1'b0);
    chk("R6 edge wins irq1", {31'b0, irq1_o}, 32'h1);
    chk("R6 clear irq12", {31'b0, irq12_o}, 32'h0);
    io_cyc(16'h0060, 1'b0);
    chk("R6 clear irq1", {31'b0, irq1_o}, 32'h0);

    // R7 enable drop discards latch
    irq1_raw_i = 1'b0;
    cyc(4);
    irq1_raw_i = 1'b1;
    cyc(3);
    chk("R7 setup latch", {31'b0, irq1_o}, 32'h1);
    irq1_raw_i = 1'b0;
    cyc(1);
    reg_wr(8'hD0, 32'h0000_0800);
    chk("R7 pass-through after disable", {31'b0, irq1_o}, 32'h0);
    irq1_raw_i = 1'b1;
    #1 chk("R3 pass-through follows", {31'b0, irq1_o}, 32'h1);
    cyc(1);
    irq1_raw_i = 1'b0;
    cyc(5);
    reg_wr(8'hD0, 32'h0000_1800);
    cyc(2);
    chk("R7 old latch discarded", {31'b0, irq1_o}, 32'h0);

    // R8 error disabled
    irq12_raw_i = 1'b0;
    ferr_ni = 1'b0;
    cyc(4);
    chk("R8 irq13 off", {31'b0, irq13_o}, 32'h0);
    chk("R8 ignne off", {31'b0, ignne_no}, 32'h1);

    // R9 enable with standing error
    reg_wr(8'hD0, 32'h0000_3800);
    cyc(1);
    chk("R9 irq13 set", {31'b0, irq13_o}, 32'h1);
    chk("R9 ignne set", {31'b0, ignne_no}, 32'h0);
    ferr_ni = 1'b1;
    cyc(4);
    chk("R9 held", {31'b0, irq13_o}, 32'h1);
    io_cyc(16'h00F0, 1'b0);
    chk("R9 read F0h ignored", {31'b0, irq13_o}, 32'h1);
    io_cyc(16'h00F0, 1'b1);
    chk("R10 cleared irq13", {31'b0, irq13_o}, 32'h0);
    chk("R10 cleared ignne", {31'b0, ignne_no}, 32'h1);
    cyc(1);
    chk("R10 stays clear", {31'b0, irq13_o}, 32'h0);

    // R10 reassert while error stands
    ferr_ni = 1'b0;
    cyc(4);
    io_cyc(16'h00F0, 1'b1);
    chk("R10 clear pulse", {31'b0, irq13_o}, 32'h0);
    cyc(1);
    chk("R10 reassert irq13", {31'b0, irq13_o}, 32'h1);
    chk("R10 reassert ignne", {31'b0, ignne_no}, 32'h0);

    // R9 timing from falling error
    ferr_ni = 1'b1;
    cyc(4);
    io_cyc(16'h00F0, 1'b1);
    ferr_ni = 1'b0;
    cyc(2);
    chk("R9 not before third edge", {31'b0, irq13_o}, 32'h0);
    cyc(1);
    chk("R9 third edge", {31'b0, irq13_o}, 32'h1);

    // R8 disable drops request at write edge
    reg_wr(8'hD0, 32'h0000_1800);
    chk("R8 disable irq13", {31'b0, irq13_o}, 32'h0);
    chk("R8 disable ignne", {31'b0, ignne_no}, 32'h1);

    // R1 decode and strobe
    reg_rd(8'hD0, 1'b1, rd);
    chk("R1 readback", rd, 32'h0000_1800);
    reg_rd(8'hD4, 1'b1, rd);
    chk("R1 other offset", rd, 32'h0);
    reg_rd(8'hD0, 1'b0, rd);
    chk("R1 no strobe", rd, 32'h0);
    reg_wr(8'hD4, 32'h0000_3800);
    reg_rd(8'hD0, 1'b1, rd);
    chk("R1 write other offset", rd, 32'h0000_1800);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule